// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Blank/Convert Control

This block is the digital core of a 10-bit successive-approximation analog-to-digital converter. The analog parts are the trial DAC, the reference and the comparator. Together they give back one bit, `cmp_above`, which reports whether the DAC sum for the current trial code is greater than the analog input. The sequencer tests the code bits one at a time, starting from the most significant. For each bit it waits a settle period before it samples the comparator.

A single control line, `blank`, runs the whole block:
- While `blank` is high the block is blanked. The ready flag is high and the data outputs float.
- Driving `blank` low starts a conversion.
- When every bit has been decided, `rdy_n` falls. A programmable number of cycles later the result is driven onto the tri-stated data pins.
- Raising `blank` after that releases the bus after a programmable hold time.
- Raising `blank` during a conversion freezes it.
  - A short high pulse lets the conversion resume where it stopped.
  - A pulse at least `RESTART_W` cycles long throws away the partial code and starts over.

A mode flag selects unipolar or bipolar operation. The flag is latched at each conversion start and presented on `offset_on`, which switches the analog half-scale offset. Every timing value is given in clock cycles.

Top module: `sar_seq`

## Requirements
- R1: While reset is active and right after it, `rdy_n` is 1, `data_drv` is 0, `trial` is 0, `done` is 0 and `offset_on` is 0.
- R2: A conversion starts with `trial` = 1 followed by W-1 zeros, so bit W-1 (the MSB) is tried first. Each trial bit is cleared when `cmp_above` is 1 and kept when it is 0. The pointer then moves down one bit. The final code is the largest code whose DAC sum does not exceed the input.
- R3: Each bit takes SETTLE+1 cycles. `done` rises exactly W*(SETTLE+1) clock edges after the edge that samples `blank` low in the blanked state. `rdy_n` falls on the edge after that.
- R4: `data_drv` stays 0 for OE_DLY cycles after `rdy_n` falls, then goes to 1. While it is 1, `data_q` carries the result and does not change.
- R5: While `blank` is held high in the blanked state, `rdy_n` stays 1 and `data_drv` stays 0.
- R6: After a result is ready, `blank` high for BLANK_DLY consecutive edges returns `rdy_n` to 1 and `data_drv` to 0. A shorter high pulse leaves `rdy_n`, `data_drv` and `data_q` unchanged.
- R7: `blank` high during a conversion halts it. `trial` is frozen, `rdy_n` stays 1 and `done` stays 0, even when the halt lands on the edge of the final bit decision. If `blank` returns low after fewer than RESTART_W high edges, the conversion resumes and keeps the bits already decided.
- R8: If `blank` returns low after at least RESTART_W high edges during a halt, a fresh conversion begins. `trial` is reloaded with the MSB alone and the mode flag is latched again.
- R9: `offset_on` takes the value of `bipolar` only at a conversion start and holds it until the next start. In bipolar mode the code is offset binary: input -512 gives 0, input 0 gives 512 (bit 9 only) and input 511 gives 1023.
- R10: `done` is high for exactly one cycle per completed conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| blank | input | 1 | 1 = blank or halt, 0 = convert |
| cmp_above | input | 1 | Comparator: trial DAC sum is greater than the analog input |
| bipolar | input | 1 | Mode request: 1 = bipolar with offset, 0 = unipolar |
| trial | output | W | Trial code driving the DAC; holds the result after completion |
| offset_on | output | 1 | Latched mode: enables the half-scale offset current |
| done | output | 1 | One-cycle pulse, one cycle before `rdy_n` falls |
| rdy_n | output | 1 | Active-low data-ready flag |
| data_drv | output | 1 | High while the data pins are driven |
| data_q | output | W | Tri-stated result bus |

## Verification
The halt and the final bit decision can fall on the same edge. The bench drives `blank` so that its rising sample meets the edge on which the last bit would otherwise be decided. It then checks that `done` stays low, `rdy_n` stays high and the code does not advance during the halt, and that a short pulse later lets the last decision finish with the correct code. The bench also provokes a second coincidence: a halt lands after two bits have been decided, and the analog value changes during the halt. Both pulse lengths are tested. The expected code is then computed from the value seen by each bit.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // Sequencer phases
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,   // blanked, outputs floating
    SQ_CONV  = 3'd1,   // stepping through trial bits
    SQ_HALT  = 3'd2,   // frozen by blank high mid-conversion
    SQ_DONE  = 3'd3,   // final decision taken, completion pulse
    SQ_VALID = 3'd4    // result ready, bus enabled after delay
  } seq_state_e;

endpackage

// File: rtl/sar_seq_rstsync.sv
module sar_seq_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/sar_seq_satcnt.sv
module sar_seq_satcnt #(
  parameter  int LIMIT = 4,
  localparam int CW    = $clog2(LIMIT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_top, cnt_en;

  assign at_top = (cnt_q == CW'(LIMIT));
  assign cnt_en = clr | (inc & ~at_top);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/sar_seq_sar.sv
module sar_seq_sar #(
  parameter int W      = 10,
  parameter int SETTLE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         run,
  input  logic         above,
  output logic [W-1:0] trial,
  output logic         last_dec
);

  localparam int SW = $clog2(SETTLE + 2);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]  trial_q, trial_d;
  logic [W-1:0]  ptr_q, ptr_d;
  logic [SW-1:0] sc_q, sc_d;
  logic          decide, reg_en;

  // a decision is taken once the settle window has elapsed
  assign decide   = run & (sc_q == SW'(SETTLE));
  assign last_dec = decide & ptr_q[0];
  assign reg_en   = start | run;

  always_comb begin
    trial_d = trial_q;
    ptr_d   = ptr_q;
    sc_d    = sc_q;
    if (start) begin
      trial_d = MSB_ONLY;
      ptr_d   = MSB_ONLY;
      sc_d    = '0;
    end else if (decide) begin
      trial_d = (trial_q & ~(ptr_q & {W{above}})) | (ptr_q >> 1);
      ptr_d   = ptr_q >> 1;
      sc_d    = '0;
    end else if (run) begin
      sc_d    = sc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      ptr_q   <= '0;
      sc_q    <= '0;
    end else if (reg_en) begin
      trial_q <= trial_d;
      ptr_q   <= ptr_d;
      sc_q    <= sc_d;
    end
  end

  assign trial = trial_q;

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_seq_pkg::*;
#(
  parameter int BLANK_DLY = 375,
  parameter int RESTART_W = 500,
  parameter int HW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blank,
  input  logic [HW-1:0] hi_cnt,
  input  logic          last_dec,
  output logic          start,
  output logic          run,
  output logic          done,
  output logic          rdy_n,
  output logic          data_phase
);

  seq_state_e st_q, st_d;
  logic       long_hi, rel_due;

  assign long_hi = (hi_cnt >= HW'(RESTART_W));
  assign rel_due = blank & (hi_cnt >= HW'(BLANK_DLY - 1));

  always_comb begin
    st_d  = st_q;
    start = 1'b0;
    run   = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (!blank) begin
          start = 1'b1;
          st_d  = SQ_CONV;
        end
      end
      SQ_CONV: begin
        // a halt wins over any decision on the same edge
        if (blank) st_d = SQ_HALT;
        else begin
          run = 1'b1;
          if (last_dec) st_d = SQ_DONE;
        end
      end
      SQ_HALT: begin
        if (!blank) begin
          start = long_hi;
          st_d  = SQ_CONV;
        end
      end
      SQ_DONE:  st_d = SQ_VALID;
      SQ_VALID: if (rel_due) st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign done       = (st_q == SQ_DONE);
  assign data_phase = (st_q == SQ_VALID);
  assign rdy_n      = ~data_phase;

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W         = 10,
  parameter int SETTLE    = 2,
  parameter int OE_DLY    = 125,
  parameter int BLANK_DLY = 375,
  parameter int RESTART_W = 500
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         blank,
  input  logic         cmp_above,
  input  logic         bipolar,
  output logic [W-1:0] trial,
  output logic         offset_on,
  output logic         done,
  output logic         rdy_n,
  output logic         data_drv,
  output logic [W-1:0] data_q
);

  localparam int HLIM = (BLANK_DLY > RESTART_W) ? BLANK_DLY : RESTART_W;
  localparam int HW   = $clog2(HLIM + 2);
  localparam int OW   = $clog2(OE_DLY + 2);

  logic          srst_n;
  logic [HW-1:0] hi_cnt;
  logic [OW-1:0] oe_cnt;
  logic          start, run, last_dec, data_phase;
  logic          offset_q;

  sar_seq_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // consecutive cycles with blank high
  sar_seq_satcnt #(.LIMIT(HLIM)) u_hicnt (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (~blank),
    .inc   (blank),
    .cnt   (hi_cnt)
  );

  // cycles since the result became ready
  sar_seq_satcnt #(.LIMIT(OE_DLY)) u_oecnt (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (~data_phase),
    .inc   (data_phase),
    .cnt   (oe_cnt)
  );

  sar_seq_sar #(.W(W), .SETTLE(SETTLE)) u_sar (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (start),
    .run      (run),
    .above    (cmp_above),
    .trial    (trial),
    .last_dec (last_dec)
  );

  sar_seq_fsm #(.BLANK_DLY(BLANK_DLY), .RESTART_W(RESTART_W), .HW(HW)) u_fsm (
    .clk        (clk),
    .rst_n      (srst_n),
    .blank      (blank),
    .hi_cnt     (hi_cnt),
    .last_dec   (last_dec),
    .start      (start),
    .run        (run),
    .done       (done),
    .rdy_n      (rdy_n),
    .data_phase (data_phase)
  );

  // mode is captured once per conversion start
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    offset_q <= 1'b0;
    else if (start) offset_q <= bipolar;
  end

  assign offset_on = offset_q;
  assign data_drv  = data_phase & (oe_cnt >= OW'(OE_DLY));

  for (genvar gi = 0; gi < W; gi++) begin : g_pad
    assign data_q[gi] = data_drv ? trial[gi] : 1'bz;
  end

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         blank,
  input logic [W-1:0] trial,
  input logic         offset_on,
  input logic         done,
  input logic         rdy_n,
  input logic         data_drv
);

  // R7: a blank-high sample never lets the code move
  a_r7_trial_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> $stable(trial));

  // R10: completion pulse lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: ready follows the completion pulse
  a_r3_rdy_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !rdy_n);

  // R3: ready only falls after a completion pulse
  a_r3_rdy_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(done));

  // R5: bus floats whenever not ready
  a_r5_float_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_n |-> !data_drv);

  // R6: ready only released by blank high
  a_r6_release_by_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_n) |-> $past(blank));

  // R4: driven data does not change
  a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (data_drv && $past(data_drv)) |-> $stable(trial));

  // R9: mode changes only at a start edge
  a_r9_mode_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset_on) |-> ($past(!blank) && $past(rdy_n)));

endmodule

bind sar_seq sar_seq_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .blank     (blank),
  .trial     (trial),
  .offset_on (offset_on),
  .done      (done),
  .rdy_n     (rdy_n),
  .data_drv  (data_drv)
);

// File: tb/sar_seq_test.sv
module sar_seq_test;

  localparam int W    = 10;
  localparam int ST   = 1;
  localparam int OE   = 3;
  localparam int BD   = 5;
  localparam int RW   = 7;
  localparam int LAT  = W * (ST + 1);
  localparam int HALF = 1 << (W - 1);
  localparam int FULL = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blank = 1'b1;
  logic bipolar = 1'b0;
  logic cmp_above;
  logic [W-1:0] trial;
  logic offset_on, done, rdy_n, data_drv;
  wire  [W-1:0] data_q;

  int vin = 0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // ideal analog model: DAC sum (with optional half-scale offset) vs input
  assign cmp_above = (int'(trial) - (offset_on ? HALF : 0)) > vin;

  sar_seq #(.W(W), .SETTLE(ST), .OE_DLY(OE), .BLANK_DLY(BD), .RESTART_W(RW)) uut (
    .clk (clk), .rst_n (rst_n), .blank (blank), .cmp_above (cmp_above),
    .bipolar (bipolar), .trial (trial), .offset_on (offset_on), .done (done),
    .rdy_n (rdy_n), .data_drv (data_drv), .data_q (data_q)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // successive approximation: the first 'keep' bits see input a, the rest see b
  function automatic int sar_ref(int a, int b, int keep, bit bip);
    int acc = 0;
    for (int i = 0; i < W; i++) begin
      int t = acc + (HALF >> i);
      int v = (i < keep) ? a : b;
      if (!((t - (bip ? HALF : 0)) > v)) acc = t;
    end
    return acc;
  endfunction

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 400) begin
      tick();
      n++;
    end
    chk(done, "R3 done seen", int'(done), 1);
  endtask

  task automatic read_out(input int exp, input string tag);
    tick();
    chk(!done, "R10 done one cycle", int'(done), 0);
    chk(!rdy_n, "R3 rdy_n falls after done", int'(rdy_n), 0);
    chk(!data_drv, "R4 bus floats at ready", int'(data_drv), 0);
    repeat (OE - 1) tick();
    chk(!data_drv, "R4 bus floats before delay", int'(data_drv), 0);
    tick();
    chk(data_drv, "R4 bus driven after delay", int'(data_drv), 1);
    chk(data_drv && int'(data_q) == exp, tag, int'(data_q), exp);
  endtask

  task automatic release_full();
    blank = 1'b1;
    repeat (BD - 1) tick();
    chk(!rdy_n, "R6 still ready before release delay", int'(rdy_n), 0);
    tick();
    chk(rdy_n && !data_drv, "R6 released after delay", int'(rdy_n), 1);
  endtask

  task automatic conv(input int v, input bit bip);
    int n;
    int exp;
    exp = bip ? v + HALF : v;
    vin = v;
    bipolar = bip;
    blank = 1'b0;
    wait_done(n);
    chk(n == LAT + 1, "R3 latency", n, LAT + 1);
    chk(offset_on == bip, "R9 mode latched", int'(offset_on), int'(bip));
    read_out(exp, bip ? "R9 bipolar code" : "R2 unipolar code");
    release_full();
  endtask

  initial begin
    int n;
    int tr;
    // R1 reset state
    repeat (3) tick();
    chk(rdy_n && !data_drv && trial == '0 && !done && !offset_on,
        "R1 state in reset", int'(trial), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(rdy_n && !data_drv && trial == '0 && !done && !offset_on,
        "R1 state after reset", int'(rdy_n), 1);

    // R5 standby stays blanked
    repeat (10) tick();
    chk(rdy_n && !data_drv, "R5 standby blanked", int'(data_drv), 0);

    // R2 MSB tried first, R9 mode toggle mid-conversion ignored
    vin = 300; bipolar = 1'b0; blank = 1'b0;
    tick();
    chk(trial == W'(HALF), "R2 first trial is MSB", int'(trial), HALF);
    repeat (3) tick();
    bipolar = 1'b1;
    wait_done(n);
    chk(!offset_on, "R9 mode held during conversion", int'(offset_on), 0);
    read_out(300, "R9 code with toggled flag");

    // R6 short release pulse ignored
    blank = 1'b1;
    repeat (BD - 1) tick();
    blank = 1'b0;
    repeat (6) tick();
    chk(!rdy_n && data_drv && int'(data_q) == 300, "R6 short pulse ignored",
        int'(data_q), 300);
    release_full();
    bipolar = 1'b0;

    // R7 halt with a short pulse resumes keeping decided bits
    vin = 700; blank = 1'b0;
    repeat (5) tick();
    blank = 1'b1;
    tick();
    tr = int'(trial);
    chk(rdy_n && !data_drv, "R7 halted blanked", int'(rdy_n), 1);
    vin = 100;
    repeat (RW - 2) tick();
    chk(int'(trial) == tr && !done, "R7 trial frozen", int'(trial), tr);
    blank = 1'b0;
    wait_done(n);
    read_out(sar_ref(700, 100, 2, 1'b0), "R7 resumed code");
    release_full();

    // R8 long pulse restarts with new mode
    vin = 700; blank = 1'b0;
    repeat (5) tick();
    blank = 1'b1;
    tick();
    bipolar = 1'b1;
    vin = -100;
    repeat (RW - 1) tick();
    blank = 1'b0;
    tick();
    chk(trial == W'(HALF), "R8 restart reloads MSB", int'(trial), HALF);
    chk(offset_on, "R8 mode relatched", int'(offset_on), 1);
    wait_done(n);
    read_out(-100 + HALF, "R8 restarted code");
    release_full();
    bipolar = 1'b0;

    // R7 halt on the edge of the final decision
    vin = 345; blank = 1'b0;
    repeat (LAT) tick();
    blank = 1'b1;
    tick();
    chk(!done && rdy_n, "R7 halt beats final decision", int'(done), 0);
    repeat (2) tick();
    chk(!done && rdy_n, "R7 no completion while halted", int'(rdy_n), 1);
    blank = 1'b0;
    wait_done(n);
    read_out(345, "R7 code after late halt");
    release_full();

    // R9 bipolar endpoints
    conv(-HALF, 1'b1);
    conv(0, 1'b1);
    conv(HALF - 1, 1'b1);

    // R2 and R9 exhaustive sweeps
    for (int v = 0; v < FULL; v++) conv(v, 1'b0);
    for (int v = -HALF; v < HALF; v++) conv(v, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule